// File: doc/BRIEF.md
# Sub-Phase Strobe Waveform Generator

This block drives a group of active-low external strobes, such as chip selects and byte-lane selects, with a time resolution finer than one bus clock. It runs on a fast clock at four times the bus clock. Each bus cycle is split into four phases, T1 to T4, one per fast clock. A microcode word supplies one 4-bit field per strobe, and each bit of a field gives the level of that strobe in one phase. The word is accepted only at the start of a bus cycle. It then shapes the strobes for that whole cycle.

The divide setting sets the resolution. With divide-by-4 or divide-by-8, every phase bit is honoured, so a strobe can change on any quarter of the bus cycle. With divide-by-2, only T1 and T3 are active. The T1 bit covers the first half of the cycle and the T3 bit covers the second half. Bits written for T2 or T4 are ignored, so a change requested on a quarter boundary moves to the next half boundary. When no valid word is offered at the start of a cycle, every strobe rests at its inactive high level for that cycle.

A 2-bit phase counter steps on every fast clock. A sync input, pulsed in the fast clock that lines up with the bus-clock rising edge, forces that clock to be T1. Every strobe output comes straight from a flop.

Top module: `wg_waveform_gen`

## Requirements
- R1: While `rst` is high, every bit of `sig_out` goes high at the next clock edge. The first clock after reset is released is phase T1.
- R2: Strobe i uses bits `word_in[4i+3:4i]`. Bit 4i+0 gives its level in T1, 4i+1 in T2, 4i+2 in T3 and 4i+3 in T4.
- R3: With `div_sel` = 2'b01 (divide-by-4) or 2'b10 (divide-by-8), the level for phase Tk is the field bit for Tk. It is registered at the edge that closes the fast-clock cycle of Tk, so it is visible during the following fast cycle.
- R4: With `div_sel` = 2'b00 (divide-by-2), the T1 bit drives both T1 and T2, and the T3 bit drives both T3 and T4. The T2 and T4 bits have no effect.
- R5: The phase advances by one on every fast clock and wraps from T4 to T1. A cycle with `bus_sync` high is always T1, whatever the count was.
- R6: `word_in`, `word_valid` and `div_sel` are sampled only in a T1 cycle. Changes to them in T2, T3 or T4 do not alter the strobes of the current bus cycle.
- R7: If `word_valid` is low in a T1 cycle, every strobe is high for all four phases of that bus cycle.
- R8: `div_sel` = 2'b11 behaves like divide-by-8, with full quarter-phase resolution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, four times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sync | input | 1 | High in the fast cycle aligned with the bus-clock rising edge; forces T1 |
| word_valid | input | 1 | Marks `word_in` as a valid microcode word (sampled in T1) |
| word_in | input | 4*NUM_SIG | Phase fields, 4 bits per strobe |
| div_sel | input | 2 | Divide setting: 00 = /2, 01 = /4, 10 = /8, 11 = /8 |
| sig_out | output | NUM_SIG | Registered strobe levels, high = inactive |

## Verification
The level for phase Tk is due one fast clock after the cycle in which Tk is current. The T1 level therefore depends on the inputs present at the edge that closes the T1 cycle. The T2 to T4 levels depend only on what was held from that edge. The bench changes inputs only on falling edges and reads `sig_out` on the next falling edge, so each read covers exactly one register stage. During T2 to T4 it drives deliberately wrong words, valid flags and divide codes, so any leak from those phases shows up at the output. The reset level is read after one rising edge with reset high, including one reset applied while strobes are driven low.

// File: rtl/wg_pkg.sv
package wg_pkg;
  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);

  typedef logic [PH_W-1:0] phase_t;

  typedef enum logic [1:0] {
    DIV_BY2  = 2'b00,
    DIV_BY4  = 2'b01,
    DIV_BY8  = 2'b10,
    DIV_RSVD = 2'b11
  } div_e;

  // Half-rate operation collapses T2 onto T1 and T4 onto T3.
  function automatic phase_t fold_phase(input phase_t p, input logic half_rate);
    phase_t r;
    r = p;
    if (half_rate) r[0] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/wg_phase_ctr.sv
module wg_phase_ctr
  import wg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bus_sync,
  output phase_t cur_ph
);
  phase_t cnt_q;

  // A sync pulse makes the present cycle T1 (R5)
  assign cur_ph = bus_sync ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= phase_t'(cur_ph + 1'b1);
  end
endmodule

// File: rtl/wg_word_hold.sv
module wg_word_hold
  import wg_pkg::*;
#(
  parameter int unsigned NUM_SIG = 6,
  localparam int unsigned WORD_W = NUM_SIG * PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic              valid_in,
  input  logic [1:0]        div_in,
  output logic [WORD_W-1:0] eff_word,
  output logic              eff_valid,
  output logic              eff_half,
  output logic [WORD_W-1:0] word_q,
  output logic              half_q
);
  logic valid_q;
  logic half_in;

  assign half_in = (div_in == DIV_BY2);

  // Capture only at the T1 boundary (R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      half_q  <= 1'b0;
    end else if (load) begin
      word_q  <= word_in;
      valid_q <= valid_in;
      half_q  <= half_in;
    end
  end

  // In T1 the fresh inputs feed the lanes directly; later phases use the held copy
  assign eff_word  = load ? word_in  : word_q;
  assign eff_valid = load ? valid_in : valid_q;
  assign eff_half  = load ? half_in  : half_q;
endmodule

// File: rtl/wg_sig_lane.sv
module wg_sig_lane
  import wg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] field,
  input  logic              valid,
  input  logic              half_rate,
  input  phase_t            phase,
  output logic              level_q
);
  phase_t sel;

  assign sel = fold_phase(phase, half_rate);

  always_ff @(posedge clk) begin
    if (rst)        level_q <= 1'b1;
    else if (valid) level_q <= field[sel];
    else            level_q <= 1'b1;
  end
endmodule

// File: rtl/wg_waveform_gen.sv
module wg_waveform_gen
  import wg_pkg::*;
#(
  parameter int unsigned NUM_SIG = 6,
  localparam int unsigned WORD_W = NUM_SIG * PHASES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sync,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_in,
  input  logic [1:0]        div_sel,
  output logic [NUM_SIG-1:0] sig_out
);
  phase_t            cur_ph;
  logic [WORD_W-1:0] eff_word;
  logic              eff_valid;
  logic              eff_half;
  logic [WORD_W-1:0] word_q;
  logic              half_q;

  wg_phase_ctr u_phase (
    .clk      (clk),
    .rst      (rst),
    .bus_sync (bus_sync),
    .cur_ph   (cur_ph)
  );

  wg_word_hold #(.NUM_SIG(NUM_SIG)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (cur_ph == '0),
    .word_in   (word_in),
    .valid_in  (word_valid),
    .div_in    (div_sel),
    .eff_word  (eff_word),
    .eff_valid (eff_valid),
    .eff_half  (eff_half),
    .word_q    (word_q),
    .half_q    (half_q)
  );

  // One lane per strobe; field layout per R2
  for (genvar g = 0; g < NUM_SIG; g++) begin : g_lane
    wg_sig_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .field     (eff_word[g*PHASES +: PHASES]),
      .valid     (eff_valid),
      .half_rate (eff_half),
      .phase     (cur_ph),
      .level_q   (sig_out[g])
    );
  end
endmodule

// File: rtl/wg_waveform_gen_chk.sv
module wg_waveform_gen_chk
  import wg_pkg::*;
#(
  parameter int unsigned NUM_SIG = 6,
  localparam int unsigned WORD_W = NUM_SIG * PHASES
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sync,
  input logic               word_valid,
  input logic [WORD_W-1:0]  word_in,
  input logic [NUM_SIG-1:0] sig_out,
  input phase_t             cur_ph,
  input logic               half_q,
  input logic [WORD_W-1:0]  word_q
);
  logic armed = 1'b0;
  logic [NUM_SIG-1:0] t1_bits;

  always_ff @(posedge clk) armed <= !rst;

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_t1
    assign t1_bits[i] = word_in[i*PHASES];
  end

  assert_phase_step_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && !bus_sync) |-> cur_ph == phase_t'($past(cur_ph) + 1'b1));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == '0 && !word_valid) |=> &sig_out);

  assert_t1_level_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_ph == '0 && word_valid) |=> sig_out == $past(t1_bits));

  assert_half_fold_R4: assert property (@(posedge clk) disable iff (rst)
    (half_q && cur_ph[0] && cur_ph != '0) |=> $stable(sig_out));

  assert_hold_word_R6: assert property (@(posedge clk) disable iff (rst)
    (cur_ph != '0) |=> $stable(word_q));

  assert_reset_high_R1: assert property (@(posedge clk)
    rst |=> &sig_out);
endmodule

bind wg_waveform_gen wg_waveform_gen_chk #(.NUM_SIG(NUM_SIG)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_sync   (bus_sync),
  .word_valid (word_valid),
  .word_in    (word_in),
  .sig_out    (sig_out),
  .cur_ph     (cur_ph),
  .half_q     (half_q),
  .word_q     (word_q)
);

// File: tb/wg_waveform_gen_tb.sv
module wg_waveform_gen_tb_top;
  localparam int CLK_P   = 10;
  localparam int NSIG    = 6;
  localparam int WW      = NSIG * 4;
  localparam int NVEC    = 8;

  // Entry: {bus_sync, valid, div_sel[1:0], word[23:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    28'hDA53C96,  // sync, valid, /4
    28'h469A5C3,  // free-run, valid, /2
    28'h9000000,  // sync, invalid, /4
    28'h6123456,  // free-run, valid, /8
    28'hFFEDCBA,  // sync, valid, code 11
    28'hC5A5A5A,  // sync, valid, /2, quarter changes
    28'h40F0F0F,  // free-run, valid, /2
    28'hE000000   // sync, valid, /8, all active
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_sync = 1'b0;
  logic            word_valid = 1'b0;
  logic [WW-1:0]   word_in = '0;
  logic [1:0]      div_sel = 2'b01;
  logic [NSIG-1:0] sig_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wg_waveform_gen #(.NUM_SIG(NSIG)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .bus_sync   (bus_sync),
    .word_valid (word_valid),
    .word_in    (word_in),
    .div_sel    (div_sel),
    .sig_out    (sig_out)
  );

  // Expected level per R2/R3/R4/R7/R8
  function automatic logic [NSIG-1:0] exp_out(input logic [WW-1:0] w, input logic v,
                                               input logic [1:0] d, input int ph);
    logic [NSIG-1:0] r;
    int idx;
    if (!v) return '1;
    idx = (d == 2'b00) ? (ph & 2) : ph;
    for (int i = 0; i < NSIG; i++) r[i] = w[4*i + idx];
    return r;
  endfunction

  function automatic string tag_of(input logic v, input logic [1:0] d,
                                   input logic s, input int k);
    string t;
    if (!v)            t = "R7";
    else if (d == 2'b00) t = "R4 R2";
    else if (d == 2'b11) t = "R8 R2";
    else               t = "R3 R2";
    if (k > 0)           t = {t, " R6"};
    if (k == 0 && !s)    t = {t, " R5"};
    return t;
  endfunction

  task automatic check(input logic [NSIG-1:0] exp, input string tag);
    n_run++;
    if (sig_out !== exp) begin
      n_fail++;
      $display("FAIL %s: sig_out=%b expected=%b", tag, sig_out, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, sample at next falling edge
  task automatic step(input logic s, input logic [WW-1:0] w, input logic v,
                      input logic [1:0] d, input logic [NSIG-1:0] exp, input string tag);
    bus_sync   = s;
    word_in    = w;
    word_valid = v;
    div_sel    = d;
    @(negedge clk);
    check(exp, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL R5: watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] wa, wb;
    repeat (2) @(negedge clk);
    check('1, "R1 reset level");
    rst = 1'b0;

    // Table walk: T1 step carries the word, T2..T4 carry noise (R6)
    for (int e = 0; e < NVEC; e++) begin
      logic          s;
      logic          v;
      logic [1:0]    d;
      logic [WW-1:0] w;
      {s, v, d, w} = VEC[e];
      step(s, w, v, d, exp_out(w, v, d, 0), tag_of(v, d, s, 0));
      for (int k = 1; k < 4; k++)
        step(1'b0, ~w, ~v, d ^ 2'b01, exp_out(w, v, d, k), tag_of(v, d, s, k));
    end

    // R5: resync in the middle of a bus cycle restarts at T1
    wa = 24'h3C3C3C;
    wb = 24'hA6A6A6;
    step(1'b1, wa, 1'b1, 2'b01, exp_out(wa, 1'b1, 2'b01, 0), "R3");
    step(1'b0, wb, 1'b1, 2'b01, exp_out(wa, 1'b1, 2'b01, 1), "R6");
    step(1'b1, wb, 1'b1, 2'b01, exp_out(wb, 1'b1, 2'b01, 0), "R5 resync");
    for (int k = 1; k < 4; k++)
      step(1'b0, wa, 1'b0, 2'b00, exp_out(wb, 1'b1, 2'b01, k), "R5 R6");

    // R7: counter wrapped to T1 without sync, no valid word, noise claims valid later
    step(1'b0, 24'h000000, 1'b0, 2'b01, '1, "R7 R5");
    for (int k = 1; k < 4; k++)
      step(1'b0, 24'h000000, 1'b1, 2'b01, '1, "R7 R6");

    // R1: reset while strobes are active
    step(1'b1, 24'h000000, 1'b1, 2'b01, '0, "R3");
    rst = 1'b1;
    @(negedge clk);
    check('1, "R1 mid-run reset");
    rst = 1'b0;
    // R1: first cycle after release is T1 even without sync
    wa = 24'h0F0F0F;
    step(1'b0, wa, 1'b1, 2'b01, exp_out(wa, 1'b1, 2'b01, 0), "R1 R5");
    step(1'b0, ~wa, 1'b1, 2'b01, exp_out(wa, 1'b1, 2'b01, 1), "R1 R6");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule